// File: doc/BRIEF.md
# Receive FIFO with line status

This block sits between a UART receive engine and the host register interface. Each character the receive engine finishes is written, with its parity-error, framing-error and break tags, into a 16-entry first-in first-out buffer. The host pops characters from the head and reads a five-bit line status word.

Error tags travel with their character. They are reported only when that character reaches the head of the buffer, and not when it arrives. The tags are copied into sticky status bits at the moment the entry becomes the head. A later status read therefore still sees them after the character has been popped.

A character that arrives while the buffer is full is thrown away and raises the overrun bit at once. The stored characters are left as they were. Reading the status word clears all four error bits. A separate buffer-clear input empties the buffer but leaves the sticky error bits as they are.

Top module: `rx_line_buffer`

## Requirements
- R1: Status bit 0 (data-ready) is 1 exactly when the buffer holds at least one character. It is 0 when the buffer is empty.
- R2: Characters leave the buffer in arrival order. Up to 16 characters are held. `rd_data` shows the head character, and a pop exposes the next one on the following cycle.
- R3: Status bit 1 (overrun) is set when a character arrives while the buffer is full and no pop happens in that cycle. That character is discarded and the stored characters are unchanged. A character that arrives on a full buffer in the same cycle as a pop is accepted.
- R4: Status bit 2 (parity error), bit 3 (framing error) and bit 4 (break) take the tags of the character at the head. They are set in the cycle after that character becomes the head. Tags of characters behind the head have no effect.
- R5: Status bits 1 to 4 stay set, even after their character is popped, until a cycle with `lsr_rd` high clears them.
- R6: When a set event and `lsr_rd` fall in the same cycle, the bit ends at 1.
- R7: `fifo_clr` empties the buffer, so bit 0 becomes 0, and keeps bits 1 to 4. A character arriving in the same cycle as `fifo_clr` is dropped.
- R8: After reset every status bit is 0.
- R9: A pop on an empty buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received character is complete this cycle |
| rx_data | input | 8 | Received character |
| rx_pe | input | 1 | Parity-error tag of the character |
| rx_fe | input | 1 | Framing-error tag of the character |
| rx_bi | input | 1 | Break tag of the character |
| rd_pop | input | 1 | Host removes the head character |
| lsr_rd | input | 1 | Host reads the status word, which clears bits 1 to 4 |
| fifo_clr | input | 1 | Empty the buffer |
| rd_data | output | 8 | Head character |
| lsr | output | 5 | Line status: {break, framing, parity, overrun, data-ready} |

## Verification
A vector table walks a mix of clean and tagged characters. It separates reporting at the head from reporting at arrival by placing a tagged character behind a clean one and checking that its tag appears only after the pop. A push and a pop in the same cycle on a one-entry buffer checks that the new head's tags come from the incoming character. Directed sequences then fill the buffer to 16 entries and check three things: a drop without a pop sets overrun and loses nothing, and a push with a pop is accepted. They also check a status read that collides with a set, a pop on an empty buffer, and a buffer clear that empties the data while the sticky bits survive.

// File: rtl/rx_line_buffer.sv
module rx_line_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_pe,
  input  logic          rx_fe,
  input  logic          rx_bi,
  input  logic          rd_pop,
  input  logic          lsr_rd,
  input  logic          fifo_clr,
  output logic [DW-1:0] rd_data,
  output logic [4:0]    lsr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_nxt, wr_nxt;
  logic [CW-1:0] count;
  logic [3:0]    err;

  logic empty, full, pop_ok, push_ok, ovr_set, head_chg;
  logic [2:0] new_tags, tag_set;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = rd_pop & ~empty & ~fifo_clr;
  assign push_ok = rx_valid & ~fifo_clr & (~full | pop_ok);
  assign ovr_set = rx_valid & ~fifo_clr & full & ~pop_ok;

  assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
  assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);

  assign head_chg = pop_ok ? ((count > CW'(1)) | push_ok) : (empty & push_ok);
  assign new_tags = (pop_ok && count > CW'(1)) ? mem[rd_nxt][EW-1:DW]
                                                : {rx_bi, rx_fe, rx_pe};
  assign tag_set  = head_chg ? new_tags : 3'b000;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {rx_bi, rx_fe, rx_pe, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (fifo_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= '0;
    else        err <= {tag_set, ovr_set} | (err & {4{~lsr_rd}});
  end

  assign rd_data = mem[rd_ptr][DW-1:0];
  assign lsr     = {err, ~empty};
endmodule

module rx_line_buffer_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_pop,
  input logic          lsr_rd,
  input logic          fifo_clr,
  input logic [4:0]    lsr,
  input logic [CW-1:0] count
);
  assert_ready_after_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !fifo_clr |=> lsr[0]);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_pop && !fifo_clr && count == CW'(DEPTH) |=> lsr[1]);

  assert_overrun_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_pop && !fifo_clr && count == CW'(DEPTH) |=> $stable(count));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid && !rd_pop |=> lsr[4:1] == 4'b0000);

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !lsr[0]);

  assert_clear_keeps_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr && !lsr_rd |=> (lsr[4:1] & $past(lsr[4:1])) == $past(lsr[4:1]));
endmodule

bind rx_line_buffer rx_line_buffer_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_pop(rd_pop),
  .lsr_rd(lsr_rd), .fifo_clr(fifo_clr), .lsr(lsr), .count(count)
);

// File: tb/test_rx_line_buffer.sv
module test_rx_line_buffer;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_pe = 0, rx_fe = 0, rx_bi = 0;
  logic rd_pop = 0, lsr_rd = 0, fifo_clr = 0;
  logic [7:0] rx_data = 0, rd_data;
  logic [4:0] lsr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_line_buffer i_rx_line_buffer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi), .rd_pop(rd_pop),
    .lsr_rd(lsr_rd), .fifo_clr(fifo_clr), .rd_data(rd_data), .lsr(lsr)
  );

  // {push, pop, lsr_rd, pe, fe, bi, data[7:0], exp_lsr[4:0], exp_head[7:0]}
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {3'b100, 3'b000, 8'h11, 5'b00001, 8'h11},  // R1 clean push
    {3'b100, 3'b100, 8'h22, 5'b00001, 8'h11},  // R4 pe behind head hidden
    {3'b010, 3'b000, 8'h00, 5'b00101, 8'h22},  // R4 pe at head
    {3'b001, 3'b000, 8'h00, 5'b00001, 8'h22},  // R5 read clears
    {3'b110, 3'b010, 8'h33, 5'b01001, 8'h33},  // R4 push+pop on one entry
    {3'b010, 3'b000, 8'h00, 5'b01000, 8'h00},  // R5 sticky after pop
    {3'b001, 3'b000, 8'h00, 5'b00000, 8'h00},  // R5
    {3'b100, 3'b001, 8'h44, 5'b10001, 8'h44},  // R4 break into empty
    {3'b101, 3'b100, 8'h55, 5'b00001, 8'h44},  // R5 read with push
    {3'b010, 3'b000, 8'h00, 5'b00101, 8'h55},  // R2 R4 order
    {3'b011, 3'b000, 8'h00, 5'b00000, 8'h00}   // R1 empty
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic push, input logic [7:0] d, input logic pe,
                     input logic fe, input logic bi, input logic pop,
                     input logic rd, input logic clr);
    rx_valid = push; rx_data = d; rx_pe = pe; rx_fe = fe; rx_bi = bi;
    rd_pop = pop; lsr_rd = rd; fifo_clr = clr;
    @(posedge clk); #1;
    rx_valid = 0; rd_pop = 0; lsr_rd = 0; fifo_clr = 0;
    rx_pe = 0; rx_fe = 0; rx_bi = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset lsr", {3'b0, lsr}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][26], VEC[i][20:13], VEC[i][23], VEC[i][22], VEC[i][21],
          VEC[i][25], VEC[i][24], 1'b0);
      chk($sformatf("R4 vec%0d lsr", i), {3'b0, lsr}, {3'b0, VEC[i][12:8]});
      if (VEC[i][8]) chk($sformatf("R2 vec%0d head", i), rd_data, VEC[i][7:0]);
    end

    for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0, 0, 0, 0, 0, 0);
    chk("R3 full no overrun", {3'b0, lsr}, 8'h01);
    cyc(1, 8'hAA, 0, 0, 0, 0, 0, 0);
    chk("R3 overrun set", {3'b0, lsr}, 8'h03);
    chk("R3 head intact", rd_data, 8'h00);
    cyc(1, 8'hAB, 0, 0, 0, 0, 1, 0);
    chk("R6 set wins over read", {3'b0, lsr}, 8'h03);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 overrun cleared", {3'b0, lsr}, 8'h01);
    cyc(1, 8'hBB, 0, 0, 0, 1, 0, 0);
    chk("R3 push with pop on full", {3'b0, lsr}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R2 order %0d", i), rd_data, (i < 15) ? 8'(i + 1) : 8'hBB);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
    end
    chk("R1 drained", {3'b0, lsr}, 8'h00);

    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9 pop on empty", {3'b0, lsr}, 8'h00);
    cyc(1, 8'h77, 0, 0, 0, 0, 0, 0);
    chk("R9 head after empty pop", rd_data, 8'h77);
    chk("R9 ready", {3'b0, lsr}, 8'h01);

    cyc(1, 8'h88, 0, 1, 0, 1, 0, 0);
    chk("R4 fe at head", {3'b0, lsr}, 8'h09);
    chk("R2 head 88", rd_data, 8'h88);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 clear keeps fe", {3'b0, lsr}, 8'h08);
    cyc(1, 8'h99, 0, 0, 0, 0, 0, 1);
    chk("R7 push during clear dropped", {3'b0, lsr}, 8'h08);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 final read", {3'b0, lsr}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule